// File: doc/BRIEF.md
# Exception Entry Arbiter and Sequencer

This block controls how a small 16-bit processor core leaves normal execution to take an exception. There are three sources. The first is the reset pin. The second is a pending interrupt that has already been prioritised, with its vector number. The third is a trap raised by the decoder when a trap instruction completes, with its trap number. The block watches instruction boundaries and the mask bit of the condition code register. It decides at each allowed point whether an exception is taken, and which one.

For an interrupt or a trap, the entry runs in a fixed order:
1. Lower the stack pointer by one word.
2. Write the saved condition code register and program counter as one word at the new stack top.
3. Set the interrupt mask bit.
4. Read the 32-bit vector table entry.
5. Load the program counter from the low 24 bits of that entry.

A reset skips the stack steps and only fetches vector 0.

Both memory requests use one valid/ready channel. A request is held with its address, write flag and data unchanged until ready is seen high on a clock edge. Read data returns on a separate response strobe that has no back-pressure and is always accepted. Interrupt and trap requests are also valid/ready. A source holds valid until the block returns ready, which it does for exactly one cycle when it takes that source.

Top module: `exc_entry_top`

## Requirements
- R1: While `res_n` is low, `busy` is high, no memory request is issued and `pc_load` stays low. After `res_n` rises, the block reads address 0 with no stack pointer update and no memory write. It then pulses `pc_load` with `pc_new` equal to bits 23:0 of the returned word.
- R2: Reset pre-empts everything, and pulling `res_n` low aborts a sequence that is in progress. When an interrupt and a trap are both acceptable in the same cycle, the interrupt is taken and the trap is left waiting.
- R3: An interrupt or a trap is taken only at a decision point while `busy` is low. A decision point is a cycle with `insn_end` high, or the cycle right after the `pc_load` of an interrupt or trap entry. A request is not taken without one, and `insn_end` while `busy` is high has no effect.
- R4: An interrupt is not taken in a cycle where `insn_end` and `insn_ccr_wr` are both high.
- R5: An interrupt is not taken in the cycle right after the `pc_load` of a reset entry.
- R6: Bit 7 of `ccr_in` is the interrupt mask. While it is 1, no interrupt is taken. A trap is taken regardless of it.
- R7: One cycle after a take, `sp_wr_en` pulses with `sp_wr_data = sp_in - 4`. The next request is a write to that address with data {ccr, pc}: the CCR in bits 31:24 and the PC in bits 23:0, both as they were in the take cycle.
- R8: The vector fetch is a read at address vector×4. An interrupt uses `irq_vec`. A trap uses vector 8 + `trap_num`. Reset uses vector 0.
- R9: In the cycle the context write is accepted, `ccr_wr_en` pulses with the saved CCR with bit 7 set.
- R10: A request that is held back by low `mem_req_ready` keeps its valid, address, write flag and data stable in the next cycle.
- R11: `irq_ready` or `trap_ready` is high only in the take cycle. `busy` is high from the cycle after the take through the `pc_load` cycle.
- R12: At the decision point right after an interrupt or trap entry, requests that are still pending are judged under the normal rules. A waiting trap is taken there without an `insn_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | Synchronous reset pin, active low; a rising edge starts reset entry |
| insn_end | input | 1 | Current instruction completes this cycle |
| insn_ccr_wr | input | 1 | The completing instruction writes the CCR directly |
| irq_valid | input | 1 | Prioritised interrupt pending |
| irq_vec | input | 8 | Interrupt vector number |
| irq_ready | output | 1 | Interrupt taken this cycle |
| trap_valid | input | 1 | Trap instruction raised |
| trap_num | input | 2 | Trap number |
| trap_ready | output | 1 | Trap taken this cycle |
| pc_in | input | 24 | Current program counter (return address) |
| ccr_in | input | 8 | Current condition code register |
| sp_in | input | 32 | Current stack pointer |
| busy | output | 1 | Entry sequence active |
| sp_wr_en | output | 1 | Stack pointer write strobe |
| sp_wr_data | output | 32 | New stack pointer |
| ccr_wr_en | output | 1 | CCR write strobe |
| ccr_wr_data | output | 8 | New CCR value |
| pc_load | output | 1 | Program counter load strobe |
| pc_new | output | 24 | Handler start address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |

## Verification
Two pairs of functions can meet in the same cycle.

The first pair is an interrupt and a trap. Both are offered on one `insn_end`. The bench judges that only `irq_ready` rises, and that the interrupt's stack and vector traffic comes first. It then judges that the trap is taken at the decision point right after the interrupt's `pc_load`, with no new `insn_end`.

The second pair is a boundary that carries a pending, unmasked interrupt together with `insn_ccr_wr`. The bench expects no take at that boundary and a take at the next plain boundary.

A reset asserted in the middle of a context push is also covered. Its outcome is judged as a clean restart through vector 0.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [2:0] {
    ST_HOLD, ST_IDLE, ST_SPDEC, ST_PUSH, ST_FETCH, ST_WAIT, ST_LOAD
  } seq_st_t;

  typedef enum logic [1:0] {
    SRC_NONE, SRC_RESET, SRC_IRQ, SRC_TRAP
  } exc_src_t;
endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
  import exc_entry_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int TRAP_W    = 2,
  parameter int TRAP_BASE = 8,
  parameter int CCR_W     = 8,
  parameter int IMASK_BIT = 7
) (
  input  logic              clk,
  input  logic              res_n,
  input  logic              idle,
  input  logic              chk,
  input  logic              insn_end,
  input  logic              insn_ccr_wr,
  input  logic              irq_valid,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic              trap_valid,
  input  logic [TRAP_W-1:0] trap_num,
  input  logic [CCR_W-1:0]  ccr_in,
  output logic              take,
  output exc_src_t          take_src,
  output logic [VEC_W-1:0]  take_vec,
  output logic              irq_ready,
  output logic              trap_ready
);
  logic decide, irq_ok;

  // decision point: idle and either an instruction boundary or end of entry
  assign decide = idle && (insn_end || chk);
  assign irq_ok = irq_valid && !ccr_in[IMASK_BIT] && !(insn_end && insn_ccr_wr);

  always_comb begin
    irq_ready  = 1'b0;
    trap_ready = 1'b0;
    take_src   = SRC_NONE;
    take_vec   = '0;
    if (decide) begin
      if (irq_ok) begin
        irq_ready = 1'b1;
        take_src  = SRC_IRQ;
        take_vec  = irq_vec;
      end else if (trap_valid) begin
        trap_ready = 1'b1;
        take_src   = SRC_TRAP;
        take_vec   = VEC_W'(TRAP_BASE) + VEC_W'(trap_num);
      end
    end
  end
  assign take = irq_ready || trap_ready;

  // R4: a boundary that writes the CCR never admits an interrupt
  p_ccr_write_blocks_r4: assert property (@(posedge clk) disable iff (!res_n)
    (insn_end && insn_ccr_wr) |-> !irq_ready);
  // R3: nothing is taken while a sequence runs
  p_no_take_busy_r3: assert property (@(posedge clk) disable iff (!res_n)
    !idle |-> !(irq_ready || trap_ready));
endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
  import exc_entry_pkg::*;
(
  input  logic     clk,
  input  logic     res_n,
  input  logic     take,
  input  exc_src_t take_src,
  input  logic     mem_req_ready,
  input  logic     mem_rsp_valid,
  output seq_st_t  state,
  output logic     chk
);
  exc_src_t src_q;
  logic     chk_q;

  always_ff @(posedge clk) begin
    if (!res_n) begin
      state <= ST_HOLD;
      src_q <= SRC_RESET;
      chk_q <= 1'b0;
    end else begin
      chk_q <= 1'b0;
      unique case (state)
        ST_HOLD:  state <= ST_FETCH;
        ST_IDLE:  if (take) begin
                    state <= ST_SPDEC;
                    src_q <= take_src;
                  end
        ST_SPDEC: state <= ST_PUSH;
        ST_PUSH:  if (mem_req_ready) state <= ST_FETCH;
        ST_FETCH: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT:  if (mem_rsp_valid) state <= ST_LOAD;
        ST_LOAD:  begin
                    state <= ST_IDLE;
                    chk_q <= (src_q != SRC_RESET);
                  end
        default:  state <= ST_HOLD;
      endcase
    end
  end

  assign chk = chk_q;

  // R5: the reset entry leaves no decision point behind it
  p_no_check_after_reset_r5: assert property (@(posedge clk) disable iff (!res_n)
    (state == ST_LOAD && src_q == SRC_RESET) |=> !chk);
  // R12: the end-of-entry decision point only exists in idle
  p_check_in_idle_r12: assert property (@(posedge clk) disable iff (!res_n)
    chk |-> state == ST_IDLE);
endmodule

// File: rtl/exc_entry_ctx.sv
module exc_entry_ctx #(
  parameter int VEC_W  = 8,
  parameter int PC_W   = 24,
  parameter int CCR_W  = 8,
  parameter int SP_W   = 32,
  localparam int WORD_W  = CCR_W + PC_W,
  localparam int SP_STEP = WORD_W / 8
) (
  input  logic              clk,
  input  logic              res_n,
  input  logic              take,
  input  logic [VEC_W-1:0]  take_vec,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [CCR_W-1:0]  ccr_in,
  input  logic [SP_W-1:0]   sp_in,
  input  logic              sp_step,
  input  logic              rsp_take,
  input  logic [WORD_W-1:0] rsp_data,
  output logic [PC_W-1:0]   pc_q,
  output logic [CCR_W-1:0]  ccr_q,
  output logic [VEC_W-1:0]  vec_q,
  output logic [SP_W-1:0]   sp_q,
  output logic [SP_W-1:0]   sp_dec,
  output logic [PC_W-1:0]   newpc_q
);
  assign sp_dec = sp_in - SP_W'(SP_STEP);

  always_ff @(posedge clk) begin
    if (!res_n) begin
      pc_q    <= '0;
      ccr_q   <= '0;
      vec_q   <= '0;
      sp_q    <= '0;
      newpc_q <= '0;
    end else begin
      if (take) begin
        pc_q  <= pc_in;
        ccr_q <= ccr_in;
        vec_q <= take_vec;
      end
      if (sp_step)  sp_q    <= sp_dec;
      if (rsp_take) newpc_q <= rsp_data[PC_W-1:0];
    end
  end

  // R8: a fetched vector word must be fully defined
  p_rsp_defined_r8: assert property (@(posedge clk) disable iff (!res_n)
    rsp_take |-> !$isunknown(rsp_data));
  // R7: the push address follows the decremented stack pointer
  p_sp_capture_r7: assert property (@(posedge clk) disable iff (!res_n)
    sp_step |=> sp_q == $past(sp_dec));
endmodule

// File: rtl/exc_entry_top.sv
module exc_entry_top
  import exc_entry_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int TRAP_W    = 2,
  parameter int TRAP_BASE = 8,
  parameter int PC_W      = 24,
  parameter int CCR_W     = 8,
  parameter int SP_W      = 32,
  parameter int IMASK_BIT = 7,
  localparam int WORD_W    = CCR_W + PC_W,
  localparam int SP_STEP   = WORD_W / 8,
  localparam int VEC_SHIFT = $clog2(SP_STEP)
) (
  input  logic              clk,
  input  logic              res_n,
  input  logic              insn_end,
  input  logic              insn_ccr_wr,
  input  logic              irq_valid,
  input  logic [VEC_W-1:0]  irq_vec,
  output logic              irq_ready,
  input  logic              trap_valid,
  input  logic [TRAP_W-1:0] trap_num,
  output logic              trap_ready,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [CCR_W-1:0]  ccr_in,
  input  logic [SP_W-1:0]   sp_in,
  output logic              busy,
  output logic              sp_wr_en,
  output logic [SP_W-1:0]   sp_wr_data,
  output logic              ccr_wr_en,
  output logic [CCR_W-1:0]  ccr_wr_data,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_new,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [SP_W-1:0]   mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  seq_st_t          state;
  exc_src_t         take_src;
  logic             take, chk, idle, push, fetch;
  logic [VEC_W-1:0] take_vec, vec_q;
  logic [PC_W-1:0]  pc_q;
  logic [CCR_W-1:0] ccr_q;
  logic [SP_W-1:0]  sp_q;

  assign idle  = (state == ST_IDLE);
  assign push  = (state == ST_PUSH);
  assign fetch = (state == ST_FETCH);

  exc_entry_arb #(
    .VEC_W(VEC_W), .TRAP_W(TRAP_W), .TRAP_BASE(TRAP_BASE),
    .CCR_W(CCR_W), .IMASK_BIT(IMASK_BIT)
  ) u_arb (
    .clk(clk), .res_n(res_n), .idle(idle), .chk(chk),
    .insn_end(insn_end), .insn_ccr_wr(insn_ccr_wr),
    .irq_valid(irq_valid), .irq_vec(irq_vec),
    .trap_valid(trap_valid), .trap_num(trap_num), .ccr_in(ccr_in),
    .take(take), .take_src(take_src), .take_vec(take_vec),
    .irq_ready(irq_ready), .trap_ready(trap_ready)
  );

  exc_entry_fsm u_fsm (
    .clk(clk), .res_n(res_n), .take(take), .take_src(take_src),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .state(state), .chk(chk)
  );

  exc_entry_ctx #(
    .VEC_W(VEC_W), .PC_W(PC_W), .CCR_W(CCR_W), .SP_W(SP_W)
  ) u_ctx (
    .clk(clk), .res_n(res_n), .take(take), .take_vec(take_vec),
    .pc_in(pc_in), .ccr_in(ccr_in), .sp_in(sp_in),
    .sp_step(state == ST_SPDEC),
    .rsp_take((state == ST_WAIT) && mem_rsp_valid),
    .rsp_data(mem_rsp_data),
    .pc_q(pc_q), .ccr_q(ccr_q), .vec_q(vec_q), .sp_q(sp_q),
    .sp_dec(sp_wr_data), .newpc_q(pc_new)
  );

  assign busy          = !idle;
  assign sp_wr_en      = (state == ST_SPDEC);
  assign pc_load       = (state == ST_LOAD);
  assign mem_req_valid = push || fetch;
  assign mem_req_we    = push;
  assign mem_req_addr  = push ? sp_q : (SP_W'(vec_q) << VEC_SHIFT);
  assign mem_req_wdata = push ? {ccr_q, pc_q} : '0;
  assign ccr_wr_en     = push && mem_req_ready;
  assign ccr_wr_data   = ccr_q | CCR_W'(1 << IMASK_BIT);

  // R1: reset pin low keeps the block quiet and busy
  p_reset_quiet_r1: assert property (@(posedge clk)
    !res_n |=> (busy && !mem_req_valid && !pc_load));
  // R2: at most one source is granted per cycle
  p_single_grant_r2: assert property (@(posedge clk) disable iff (!res_n)
    !(irq_ready && trap_ready));
  // R3: an interrupt only at a boundary or right after an entry
  p_irq_at_point_r3: assert property (@(posedge clk) disable iff (!res_n)
    irq_ready |-> (insn_end || $past(pc_load)));
  // R6: a masked interrupt is never taken
  p_mask_holds_r6: assert property (@(posedge clk) disable iff (!res_n)
    ccr_in[IMASK_BIT] |-> !irq_ready);
  // R10: a stalled request holds still
  p_req_stable_r10: assert property (@(posedge clk) disable iff (!res_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
  // R11: a grant is followed by busy
  p_busy_after_take_r11: assert property (@(posedge clk) disable iff (!res_n)
    (irq_ready || trap_ready) |=> busy);
endmodule

// File: tb/exc_entry_top_test.sv
`timescale 1ns/100ps
module exc_entry_top_test;
  typedef struct packed {
    logic [2:0]  k;
    logic [31:0] a;
    logic [31:0] d;
  } ev_t;
  localparam logic [2:0] K_SPW = 3'd0, K_MWR = 3'd1, K_CCW = 3'd2, K_MRD = 3'd3, K_PCL = 3'd4;

  logic clk = 1'b0;
  logic res_n = 1'b0;
  logic insn_end = 1'b0, insn_ccr_wr = 1'b0;
  logic irq_valid = 1'b0, trap_valid = 1'b0;
  logic [7:0] irq_vec = '0;
  logic [1:0] trap_num = '0;
  logic irq_ready, trap_ready, busy, sp_wr_en, ccr_wr_en, pc_load;
  logic [31:0] sp_wr_data, mem_req_addr, mem_req_wdata;
  logic [7:0] ccr_wr_data;
  logic [23:0] pc_new;
  logic mem_req_valid, mem_req_we;
  logic mem_req_ready = 1'b0;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [23:0] pc_m = 24'h001234;
  logic [31:0] sp_m = 32'h0000_8000;
  logic [7:0] ccr_m = 8'h00;

  int ncmp = 0, nmis = 0;
  ev_t exq[$];

  always #2.5 clk = ~clk;

  exc_entry_top uut (
    .clk(clk), .res_n(res_n), .insn_end(insn_end), .insn_ccr_wr(insn_ccr_wr),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ready(irq_ready),
    .trap_valid(trap_valid), .trap_num(trap_num), .trap_ready(trap_ready),
    .pc_in(pc_m), .ccr_in(ccr_m), .sp_in(sp_m), .busy(busy),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .ccr_wr_en(ccr_wr_en), .ccr_wr_data(ccr_wr_data),
    .pc_load(pc_load), .pc_new(pc_new),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] vt(input logic [31:0] a);
    return {8'hC3, 24'h040000 + a[23:0] * 24'd16};
  endfunction

  function automatic string ktag(input logic [2:0] k);
    case (k)
      K_SPW:   return "R7 sp decrement";
      K_MWR:   return "R7 context push";
      K_CCW:   return "R9 mask set";
      K_MRD:   return "R8 vector read";
      default: return "R1/R8 pc load";
    endcase
  endfunction

  task automatic chkeq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic [2:0] k, input logic [31:0] a, input logic [31:0] d);
    exq.push_back('{k: k, a: a, d: d});
  endtask

  task automatic expect_entry(input logic [7:0] vec);
    logic [31:0] s, va, w;
    s  = sp_m - 32'd4;
    va = {22'b0, vec, 2'b00};
    w  = vt(va);
    push_exp(K_SPW, '0, s);
    push_exp(K_MWR, s, {ccr_m, pc_m});
    push_exp(K_CCW, '0, {24'b0, ccr_m | 8'h80});
    push_exp(K_MRD, va, '0);
    push_exp(K_PCL, '0, {8'b0, w[23:0]});
  endtask

  task automatic expect_reset();
    logic [31:0] w;
    w = vt(32'd0);
    push_exp(K_MRD, '0, '0);
    push_exp(K_PCL, '0, {8'b0, w[23:0]});
  endtask

  task automatic wait_done();
    int n = 0;
    do begin
      @(negedge clk); #1.5;
      n++;
    end while ((busy || exq.size() != 0) && n < 300);
    chkeq("R11 sequence ends with busy low", {31'b0, busy}, 32'd0);
    chkeq("R11 all expected traffic seen", exq.size(), 32'd0);
  endtask

  // datapath model
  always @(posedge clk) begin
    if (sp_wr_en)  sp_m  <= sp_wr_data;
    if (ccr_wr_en) ccr_m <= ccr_wr_data;
    if (pc_load)   pc_m  <= pc_new;
  end

  // memory model: stalls on a fixed pattern, reads answer one cycle later
  int rc = 0;
  logic rd_pend = 1'b0;
  logic [31:0] rd_addr = '0;
  always @(negedge clk) begin
    rc++;
    mem_req_ready = ((rc % 5) != 2) && ((rc % 7) != 3);
    mem_rsp_valid = rd_pend;
    mem_rsp_data  = rd_pend ? vt(rd_addr) : 32'h0;
    rd_pend       = mem_req_valid && mem_req_ready && !mem_req_we;
    rd_addr       = mem_req_addr;
  end

  // monitor: compares each observed event to the scoreboard queue
  task automatic observe(input logic [2:0] k, input logic [31:0] a, input logic [31:0] d);
    ev_t e;
    ncmp++;
    if (exq.size() == 0) begin
      nmis++;
      $display("FAIL %s: got unexpected kind %0d a %h d %h expected nothing", ktag(k), k, a, d);
    end else begin
      e = exq.pop_front();
      if (e.k !== k || e.a !== a || e.d !== d) begin
        nmis++;
        $display("FAIL %s: got kind %0d a %h d %h expected kind %0d a %h d %h",
                 ktag(e.k), k, a, d, e.k, e.a, e.d);
      end
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (res_n) begin
      if (sp_wr_en) observe(K_SPW, '0, sp_wr_data);
      if (mem_req_valid && mem_req_ready)
        observe(mem_req_we ? K_MWR : K_MRD, mem_req_addr, mem_req_wdata);
      if (ccr_wr_en) observe(K_CCW, '0, {24'b0, ccr_wr_data});
      if (pc_load) observe(K_PCL, '0, {8'b0, pc_new});
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nmis++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (5) @(negedge clk);
    #0.5;
    chkeq("R1 busy in reset", {31'b0, busy}, 32'd1);
    chkeq("R1 no request in reset", {31'b0, mem_req_valid}, 32'd0);
    chkeq("R1 no pc load in reset", {31'b0, pc_load}, 32'd0);
    irq_valid = 1'b1; irq_vec = 8'h21;
    expect_reset();
    @(negedge clk); res_n = 1'b1;
    wait_done();
    // R5: first idle cycle after reset entry does not take the interrupt
    chkeq("R5 no interrupt after reset entry", {31'b0, irq_ready}, 32'd0);
    chkeq("R1 pc from reset vector", {8'b0, pc_m}, {8'b0, 24'h040000});
    // R3: pending without a boundary is not taken
    @(negedge clk); #0.5;
    chkeq("R3 no boundary no take", {31'b0, irq_ready}, 32'd0);
    @(negedge clk); insn_end = 1'b1;
    expect_entry(8'h21);
    #0.5;
    chkeq("R3 interrupt at boundary", {31'b0, irq_ready}, 32'd1);
    chkeq("R2 no trap grant alongside", {31'b0, trap_ready}, 32'd0);
    @(negedge clk); insn_end = 1'b0; irq_valid = 1'b0;
    #0.5;
    chkeq("R11 busy after take", {31'b0, busy}, 32'd1);
    chkeq("R11 ready is one cycle", {31'b0, irq_ready}, 32'd0);
    wait_done();
    chkeq("R9 mask bit in ccr", {24'b0, ccr_m}, 32'h80);

    // R6: masked interrupt ignored, trap taken anyway
    @(negedge clk); irq_valid = 1'b1; irq_vec = 8'h22; insn_end = 1'b1;
    #0.5;
    chkeq("R6 masked interrupt not taken", {31'b0, irq_ready}, 32'd0);
    @(negedge clk); insn_end = 1'b0;
    @(negedge clk); trap_valid = 1'b1; trap_num = 2'd3; insn_end = 1'b1;
    expect_entry(8'd11);
    #0.5;
    chkeq("R6 trap taken while masked", {31'b0, trap_ready}, 32'd1);
    @(negedge clk); trap_valid = 1'b0; insn_end = 1'b0;
    wait_done();

    // R4: ccr-writing boundary suppresses the interrupt
    @(negedge clk); ccr_m = 8'h00; irq_vec = 8'h23; insn_end = 1'b1; insn_ccr_wr = 1'b1;
    #0.5;
    chkeq("R4 ccr write boundary blocks interrupt", {31'b0, irq_ready}, 32'd0);
    @(negedge clk); insn_ccr_wr = 1'b0;
    expect_entry(8'h23);
    #0.5;
    chkeq("R4 next plain boundary takes it", {31'b0, irq_ready}, 32'd1);
    @(negedge clk); insn_end = 1'b0; irq_valid = 1'b0;
    wait_done();

    // R2 / R12: interrupt and trap together
    @(negedge clk); ccr_m = 8'h00; irq_valid = 1'b1; irq_vec = 8'h24;
    trap_valid = 1'b1; trap_num = 2'd1; insn_end = 1'b1;
    expect_entry(8'h24);
    #0.5;
    chkeq("R2 interrupt wins", {31'b0, irq_ready}, 32'd1);
    chkeq("R2 trap waits", {31'b0, trap_ready}, 32'd0);
    @(negedge clk); irq_valid = 1'b0; insn_end = 1'b0;
    #0.5;
    // R3: a boundary while busy has no effect
    insn_end = 1'b1;
    #0.2;
    chkeq("R3 boundary ignored while busy", {31'b0, trap_ready}, 32'd0);
    @(negedge clk); insn_end = 1'b0;
    do begin @(negedge clk); #0.5; end while (!pc_load);
    @(negedge clk);
    expect_entry(8'd9);
    #0.5;
    chkeq("R12 trap taken at end of entry", {31'b0, trap_ready}, 32'd1);
    @(negedge clk); trap_valid = 1'b0;
    wait_done();

    // R8: highest interrupt vector
    @(negedge clk); ccr_m = 8'h00; irq_valid = 1'b1; irq_vec = 8'hFF; insn_end = 1'b1;
    expect_entry(8'hFF);
    #0.5;
    chkeq("R8 top vector taken", {31'b0, irq_ready}, 32'd1);
    @(negedge clk); irq_valid = 1'b0; insn_end = 1'b0;
    wait_done();

    // R2: reset during a context push aborts and restarts
    @(negedge clk); ccr_m = 8'h00; irq_valid = 1'b1; irq_vec = 8'h26; insn_end = 1'b1;
    expect_entry(8'h26);
    @(negedge clk); irq_valid = 1'b0; insn_end = 1'b0;
    @(negedge clk); res_n = 1'b0;
    #1.5; exq.delete();
    repeat (3) @(negedge clk);
    #0.5;
    chkeq("R2 reset aborts: busy", {31'b0, busy}, 32'd1);
    chkeq("R2 reset aborts: no request", {31'b0, mem_req_valid}, 32'd0);
    expect_reset();
    @(negedge clk); res_n = 1'b1;
    wait_done();
    chkeq("R1 restart through vector 0", {8'b0, pc_m}, {8'b0, 24'h040000});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
    $finish;
  end
endmodule